// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block sits in front of a group of streaming-processor lanes and decides which resident warp issues next. Each warp is a bundle of threads that all execute the same instruction. Because there are fewer lanes than threads in a warp, one warp instruction is spread across several back-to-back beats. With the default sizes, 32 threads run over 8 lanes in 4 beats. On every beat the block gives each lane a valid bit, the index of the thread it serves and that thread's active bit. Threads that are switched off by divergent control flow still occupy their lane slot, but their active bit is low.

The scheduler is fine-grain multithreaded over up to 24 warp contexts, and each context keeps its own program counter. A warp is eligible when its ready flag is high and no memory wait is pending on it. A new warp is chosen only between whole warp instructions, in round-robin order. Warps that are stalled on memory are passed over, so other warps fill the lanes while the stalled ones wait.

The control has two states. In IDLE no lane is valid. In ISSUE beats are produced. The transitions are as follows. IDLE to ISSUE happens when a selection finds an eligible warp with a non-zero mask. IDLE to IDLE happens when it finds none. ISSUE to ISSUE happens either to step the beat, or at the last beat when the next selection is live. ISSUE to IDLE happens at the last beat when the next selection is empty or finds only a warp whose mask is all zeros.

Top module: `simt_warp_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all lane valid bits, active bits, thread indices, the warp ID and the PC output are zero. Every warp PC resets to 0, and no memory wait is pending.
- R2: A selection takes the first eligible warp in increasing index order, starting just after the last selected warp and wrapping round. After reset the search starts at warp 0.
- R3: A selected warp issues for exactly WARP_SIZE/NUM_LANES consecutive cycles. On beat k, lane j reports thread index NUM_LANES*k + j in bits [j*TID_W +: TID_W] of the thread-index bus, and all lane valid bits are high.
- R4: On beat k, lane j's active bit equals bit NUM_LANES*k + j of that warp's mask. The mask is the value held in bits [w*WARP_SIZE +: WARP_SIZE] of the mask bus at the selection edge.
- R5: The warp ID output does not change during a warp instruction. A new selection happens only in an idle cycle or on the last beat, and the first beat of the chosen warp follows in the next cycle.
- R6: A memory-wait set for warp w makes w ineligible at every selection after the edge that registers it. A clear makes w eligible again from the following selection. When set and clear name the same warp in the same cycle, the set wins.
- R7: A selected warp whose mask is all zeros issues no beats. Its PC still advances, it becomes the round-robin reference, and the cycle after that selection has no valid lane.
- R8: When no warp is eligible at a selection, all lane outputs stay low in the following cycle and in each later cycle until an eligible warp is selected.
- R9: During a warp's beats, the PC output shows that warp's PC as it was at selection. Each selection of a warp, with or without beats, increments its PC by one, wrapping modulo 2^PC_W.
- R10: A warp whose ready flag is low at a selection edge is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_mask | input | NUM_WARPS*WARP_SIZE | Per-warp thread active masks, warp w in bits [w*WARP_SIZE +: WARP_SIZE] |
| wait_set | input | 1 | Mark a warp as waiting on memory |
| wait_set_id | input | WID_W | Warp to mark as waiting |
| wait_clr | input | 1 | Release a warp's memory wait |
| wait_clr_id | input | WID_W | Warp to release |
| lane_valid | output | NUM_LANES | Per-lane issue valid |
| lane_active | output | NUM_LANES | Per-lane thread active bit |
| lane_tid | output | NUM_LANES*TID_W | Per-lane thread index within the warp |
| issue_warp | output | WID_W | Warp being issued (zero when idle) |
| issue_pc | output | PC_W | PC of the warp being issued (zero when idle) |

## Verification
The bench keeps the default 32-thread warps and 8 lanes, so each issue takes four beats. It reduces the design to 5 warps and a 3-bit PC. With only 5 warps the round-robin pointer wraps every few instructions, and the PC wrap from 7 back to 0 shows up within a few hundred cycles. A behavioural model runs alongside the design and is compared every cycle. Directed phases cover these cases:
- a not-ready warp;
- a memory wait that is set, and then cleared;
- a set and a clear in the same cycle;
- a zero mask;
- a fully stalled pool.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } sched_state_e;
endpackage

// File: rtl/simt_rr_pick.sv
module simt_rr_pick #(
    parameter int N = 24,
    parameter int W = 5
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = W'(idx);
            end
        end
    end
endmodule

// File: rtl/simt_wait_track.sv
module simt_wait_track #(
    parameter int N = 24,
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_vld,
    input  logic [W-1:0] set_id,
    input  logic         clr_vld,
    input  logic [W-1:0] clr_id,
    output logic [N-1:0] waiting
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waiting <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (set_vld && set_id == W'(i))
                    waiting[i] <= 1'b1;
                else if (clr_vld && clr_id == W'(i))
                    waiting[i] <= 1'b0;
            end
        end
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && clr_vld && set_id == clr_id && int'(set_id) < N)
            |=> waiting[int'($past(set_id))]);
endmodule

// File: rtl/simt_lane_spread.sv
module simt_lane_spread #(
    parameter int NL     = 8,
    parameter int WS     = 32,
    parameter int TID_W  = 5,
    parameter int BEAT_W = 2
) (
    input  logic              busy,
    input  logic [BEAT_W-1:0] beat,
    input  logic [WS-1:0]     mask,
    output logic [NL-1:0]     valid,
    output logic [NL-1:0]     active,
    output logic [NL*TID_W-1:0] tid
);
    for (genvar j = 0; j < NL; j++) begin : g_lane
        assign valid[j]  = busy;
        assign active[j] = busy & mask[int'(beat) * NL + j];
        assign tid[j*TID_W +: TID_W] = busy ? TID_W'(int'(beat) * NL + j) : '0;
    end
endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
    import simt_sched_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int WARP_SIZE = 32,
    parameter int NUM_LANES = 8,
    parameter int PC_W      = 16,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int TID_W    = (WARP_SIZE > 1) ? $clog2(WARP_SIZE) : 1,
    localparam int BEATS    = WARP_SIZE / NUM_LANES,
    localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WARPS-1:0]           warp_ready,
    input  logic [NUM_WARPS*WARP_SIZE-1:0] warp_mask,
    input  logic                           wait_set,
    input  logic [WID_W-1:0]               wait_set_id,
    input  logic                           wait_clr,
    input  logic [WID_W-1:0]               wait_clr_id,
    output logic [NUM_LANES-1:0]           lane_valid,
    output logic [NUM_LANES-1:0]           lane_active,
    output logic [NUM_LANES*TID_W-1:0]     lane_tid,
    output logic [WID_W-1:0]               issue_warp,
    output logic [PC_W-1:0]                issue_pc
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    sched_state_e            state_q, state_d;
    logic [BEAT_W-1:0]       beat_q;
    logic [WID_W-1:0]        warp_q, rr_q;
    logic [WARP_SIZE-1:0]    mask_q;
    logic [PC_W-1:0]         pc_lat_q;
    logic [PC_W-1:0]         pc_q [NUM_WARPS];
    logic [NUM_WARPS-1:0]    waiting, eligible;
    logic                    found, sel_slot, cand_live;
    logic [WID_W-1:0]        pick;
    logic [WARP_SIZE-1:0]    cand_mask;

    simt_wait_track #(.N(NUM_WARPS), .W(WID_W)) u_wait (
        .clk(clk), .rst_n(rst_n),
        .set_vld(wait_set), .set_id(wait_set_id),
        .clr_vld(wait_clr), .clr_id(wait_clr_id),
        .waiting(waiting)
    );

    assign eligible = warp_ready & ~waiting;

    simt_rr_pick #(.N(NUM_WARPS), .W(WID_W)) u_pick (
        .req(eligible), .last(rr_q), .found(found), .pick(pick)
    );

    assign sel_slot  = (state_q == ST_IDLE) || (beat_q == LAST_BEAT);
    assign cand_mask = warp_mask[int'(pick) * WARP_SIZE +: WARP_SIZE];
    assign cand_live = found && (|cand_mask);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = cand_live ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: if (beat_q == LAST_BEAT)
                          state_d = cand_live ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // beat, selection and per-warp PC registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q   <= '0;
            warp_q   <= '0;
            mask_q   <= '0;
            pc_lat_q <= '0;
            rr_q     <= WID_W'(NUM_WARPS - 1);
            for (int i = 0; i < NUM_WARPS; i++) pc_q[i] <= '0;
        end else if (sel_slot) begin
            beat_q <= '0;
            if (found) begin
                rr_q <= pick;
                for (int i = 0; i < NUM_WARPS; i++)
                    if (pick == WID_W'(i)) pc_q[i] <= pc_q[i] + 1'b1;
            end
            if (cand_live) begin
                warp_q   <= pick;
                mask_q   <= cand_mask;
                pc_lat_q <= pc_q[pick];
            end
        end else begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    simt_lane_spread #(.NL(NUM_LANES), .WS(WARP_SIZE), .TID_W(TID_W), .BEAT_W(BEAT_W)) u_spread (
        .busy(state_q == ST_ISSUE), .beat(beat_q), .mask(mask_q),
        .valid(lane_valid), .active(lane_active), .tid(lane_tid)
    );

    always_comb begin
        issue_warp = (state_q == ST_ISSUE) ? warp_q   : '0;
        issue_pc   = (state_q == ST_ISSUE) ? pc_lat_q : '0;
    end

    p_pick_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (warp_ready[pick] && !waiting[pick]));

    p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && beat_q != LAST_BEAT) |=> (beat_q == $past(beat_q) + 1'b1));

    p_active_in_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_active & ~lane_valid) == '0);

    p_warp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && beat_q != LAST_BEAT) |=> ($stable(issue_warp) && (&lane_valid)));

    p_live_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && beat_q == '0) |-> (mask_q != '0));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (lane_valid == '0 && lane_active == '0));
endmodule

// File: tb/tb_simt_warp_sched.sv
`timescale 1ns/1ps
module tb_simt_warp_sched;
    localparam int NW = 5, WS = 32, NL = 8, PCW = 3;
    localparam int WIDW = 3, TIDW = 5, BEATS = WS / NL;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NW-1:0] warp_ready = '0;
    logic [NW*WS-1:0] warp_mask = '0;
    logic wait_set = 1'b0, wait_clr = 1'b0;
    logic [WIDW-1:0] wait_set_id = '0, wait_clr_id = '0;
    logic [NL-1:0] lane_valid, lane_active;
    logic [NL*TIDW-1:0] lane_tid;
    logic [WIDW-1:0] issue_warp;
    logic [PCW-1:0] issue_pc;

    simt_warp_sched #(.NUM_WARPS(NW), .WARP_SIZE(WS), .NUM_LANES(NL), .PC_W(PCW)) dut (
        .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_mask(warp_mask),
        .wait_set(wait_set), .wait_set_id(wait_set_id), .wait_clr(wait_clr),
        .wait_clr_id(wait_clr_id), .lane_valid(lane_valid), .lane_active(lane_active),
        .lane_tid(lane_tid), .issue_warp(issue_warp), .issue_pc(issue_pc)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit compare_on = 1'b0;
    int starts [NW];   // beat-0 observations per warp

    // behavioural reference
    bit m_busy; int m_beat, m_warp, m_rr, m_pclat;
    bit [WS-1:0] m_mask;
    int m_pc [NW]; bit m_wait [NW];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_beat = 0; m_warp = 0; m_rr = NW - 1; m_pclat = 0; m_mask = '0;
            for (int i = 0; i < NW; i++) begin m_pc[i] = 0; m_wait[i] = 0; end
        end else begin
            bit old_wait [NW];
            int cand;
            for (int i = 0; i < NW; i++) old_wait[i] = m_wait[i];
            if (wait_clr) m_wait[wait_clr_id] = 0;
            if (wait_set) m_wait[wait_set_id] = 1;
            if (!m_busy || m_beat == BEATS - 1) begin
                cand = -1;
                for (int k = 1; k <= NW; k++) begin
                    int idx;
                    idx = (m_rr + k) % NW;
                    if (cand < 0 && warp_ready[idx] && !old_wait[idx]) cand = idx;
                end
                m_busy = 0;
                if (cand >= 0) begin
                    m_rr = cand;
                    if (warp_mask[cand*WS +: WS] != '0) begin
                        m_busy = 1; m_beat = 0; m_warp = cand;
                        m_mask = warp_mask[cand*WS +: WS]; m_pclat = m_pc[cand];
                    end
                    m_pc[cand] = (m_pc[cand] + 1) % (1 << PCW);
                end
            end else begin
                m_beat = m_beat + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            logic [NL-1:0] ev, ea;
            logic [NL*TIDW-1:0] et;
            for (int j = 0; j < NL; j++) begin
                ev[j] = m_busy;
                ea[j] = m_busy ? m_mask[m_beat*NL + j] : 1'b0;
                et[j*TIDW +: TIDW] = m_busy ? TIDW'(m_beat*NL + j) : '0;
            end
            chk("R8", "lane_valid", lane_valid, ev);          // also R3 valid span
            chk("R3", "lane_tid", lane_tid, et);
            chk("R4", "lane_active", lane_active, ea);
            chk("R2", "issue_warp", issue_warp, m_busy ? m_warp : 0);  // R5 hold
            chk("R9", "issue_pc", issue_pc, m_busy ? m_pclat : 0);
            if (lane_valid[0] && lane_tid[TIDW-1:0] == '0) starts[issue_warp]++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_starts();
        for (int i = 0; i < NW; i++) starts[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) starts[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "lane_valid in reset", lane_valid, 0);
        chk("R1", "issue_pc in reset", issue_pc, 0);
        warp_mask[0*WS +: WS] = 32'hFFFF_FFFF;
        warp_mask[1*WS +: WS] = 32'h0000_FFFF;
        warp_mask[2*WS +: WS] = 32'hA5C3_5A3C;
        warp_mask[3*WS +: WS] = 32'h8000_0001;
        warp_mask[4*WS +: WS] = 32'hFFFF_0000;
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);
        chk("R1", "first cycle after reset idle", lane_valid, 0);
        // R2/R3/R4/R9: all warps ready, long enough to wrap PCs
        warp_ready = '1;
        cycles(180);
        // R10: warp 2 not ready
        clear_starts();
        warp_ready[2] = 1'b0;
        cycles(60);
        chk("R10", "starts of unready warp 2", starts[2], 0);
        chk("R2", "others still served", starts[0] > 0, 1);
        warp_ready[2] = 1'b1;
        // R6: memory wait on warp 1
        wait_set = 1'b1; wait_set_id = 3'd1;
        @(negedge clk);
        wait_set = 1'b0;
        cycles(5);
        clear_starts();
        cycles(60);
        chk("R6", "starts of waiting warp 1", starts[1], 0);
        wait_clr = 1'b1; wait_clr_id = 3'd1;
        @(negedge clk);
        wait_clr = 1'b0;
        clear_starts();
        cycles(40);
        chk("R6", "warp 1 eligible after clear", starts[1] > 0, 1);
        // R6: set and clear together on warp 3, set wins
        wait_set = 1'b1; wait_set_id = 3'd3; wait_clr = 1'b1; wait_clr_id = 3'd3;
        @(negedge clk);
        wait_set = 1'b0; wait_clr = 1'b0;
        cycles(5);
        clear_starts();
        cycles(40);
        chk("R6", "set wins over clear", starts[3], 0);
        wait_clr = 1'b1; wait_clr_id = 3'd3;
        @(negedge clk);
        wait_clr = 1'b0;
        // R7: zero mask on warp 4
        warp_mask[4*WS +: WS] = '0;
        cycles(5);
        clear_starts();
        cycles(60);
        chk("R7", "zero-mask warp issues no beats", starts[4], 0);
        warp_mask[4*WS +: WS] = 32'h0000_0100;
        cycles(40);
        // R8: nothing eligible
        warp_ready = '0;
        cycles(6);
        clear_starts();
        cycles(20);
        chk("R8", "no issue when pool stalled", lane_valid, 0);
        chk("R8", "no beats started while stalled", starts[0] + starts[1] + starts[2] + starts[3] + starts[4], 0);
        warp_ready = 5'b01000;
        cycles(30);
        chk("R2", "single ready warp reissued", starts[3] > 0, 1);
        warp_ready = '1;
        cycles(40);
        compare_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule